// File: doc/BRIEF.md
# Single-Step Address Search Sequencer

This block carries out one bit position of a bus address search on a single-wire device bus. When started it asks a bit-level slot engine for two read slots in a row: the first returns the address bit that the attached devices present, and the second returns the complement of that bit. From the two answers it works out whether any device is present, whether devices disagree at this position, or whether all of them agree. It then asks for one write slot that sends the chosen branch direction back onto the bus, so that only devices on that branch stay in the search. The host supplies a preferred direction, which is used only when devices disagree.

The host side is a start pulse, the preferred direction, and on completion a one-cycle done pulse with a 3-bit result code and a timeout error flag. The slot engine side is a valid/ready request channel (a slot kind plus a bit to write) and a one-cycle response pulse carrying the bit read. The request channel follows back-pressure rules: once the request valid is raised, it and its slot kind and bit stay unchanged until ready is seen high at a clock edge. The one exception is an abort, which may withdraw the request. The response channel has no back-pressure; a response is taken only while a slot is outstanding. Sequencing over all bit positions of an address and the electrical timing of each slot live outside this block.

Top module: `triplet_seq`

## Requirements
- R1: A start pulse is accepted only while the block is idle. A start, or a change of the preferred direction, arriving while a step is in progress has no effect on that step. The preferred direction is captured in the cycle the start is accepted.
- R2: Every slot is requested on the request channel. slot_req_write is 0 for a read slot and 1 for a write slot. The request stays valid and unchanged until slot_req_ready is sampled high. The first slot reads the address bit and the second reads its complement.
- R3: A slot is requested only after the previous slot's response has been received. Each response is accepted only after its request was taken, and the next request is raised in the cycle after that response.
- R4: If both reads return 1, no device is present. The step ends after the second read with result 3'b011 and error 0, and no write slot is requested.
- R5: If both reads return 0, the write slot sends the preferred direction captured at start. The result is 3'b100 when that direction is 1 and 3'b000 when it is 0.
- R6: If exactly one read returns 1, the write slot sends the address bit. The result is 3'b101 when the address bit is 1 and 3'b010 when the complement is 1.
- R7: Result layout: bit 0 holds the address bit read, bit 1 holds the complement read, and bit 2 holds the direction sent in the write slot (the write slot's slot_req_bit). Read requests drive slot_req_bit to 0.
- R8: A slot is counted from its first cycle with the request raised. If its response has not arrived by the TIMEOUT_CYCLES-th such cycle, the step aborts: the request is withdrawn, and done pulses with result 3'b011 and timeout_err 1. A response that arrives in that last cycle completes the slot normally.
- R9: done is high for exactly one cycle. It comes in the cycle after the final response, or after the cycle in which the timeout is reached. result and timeout_err change only together with done and hold until the next done.
- R10: After reset the block is idle, with no request raised, done 0, result 3'b000 and timeout_err 0.
- R11: A response pulse that arrives while the block is idle, or while a request is raised but not yet taken, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one search step (taken only when idle) |
| pref_dir | input | 1 | Direction to take when devices disagree |
| slot_req_valid | output | 1 | Slot request present |
| slot_req_ready | input | 1 | Slot engine takes the request |
| slot_req_write | output | 1 | 1 = write slot, 0 = read slot |
| slot_req_bit | output | 1 | Bit to send in a write slot, 0 for reads |
| slot_rsp_valid | input | 1 | One-cycle slot completion pulse |
| slot_rsp_bit | input | 1 | Bit read in the completed slot |
| done | output | 1 | One-cycle end-of-step pulse |
| result | output | 3 | {direction, complement, address bit} or 3'b011 |
| timeout_err | output | 1 | Step ended by a slot timeout |

## Verification
The hardest behaviour to bring about from the ports is the timeout edge. A response that lands in the last allowed cycle must still complete the slot, and a response one cycle later must abort the step. An abort must also work while the request is still waiting for ready. The bench's slot engine model has a programmable delay before ready and before each response. It can also hold back ready, or the response, in a chosen slot. The delays are set to TIMEOUT_CYCLES-2 and TIMEOUT_CYCLES-1 so that the step lands on each side of the limit. Stray response pulses and start pulses given mid-step are also injected while the per-cycle reference model tracks every output.

// File: rtl/triplet_pkg.sv
package triplet_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    SL_ADDR = 2'd0,
    SL_COMP = 2'd1,
    SL_DIR  = 2'd2
  } slot_kind_e;

  localparam int unsigned CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_ABSENT = 3'b011;

  function automatic logic [CODE_W-1:0] pack_code(input logic dir, input logic comp, input logic addr);
    return {dir, comp, addr};
  endfunction

endpackage

// File: rtl/triplet_decide.sv
module triplet_decide
  import triplet_pkg::*;
(
  input  logic              addr_bit,
  input  logic              comp_bit,
  input  logic              pref,
  output logic              dir,
  output logic [CODE_W-1:0] code
);

  logic absent;
  logic split;

  always_comb begin
    absent = addr_bit & comp_bit;
    split  = ~(addr_bit | comp_bit);
    // one answering value decides; disagreement falls back to the host choice
    dir    = split ? pref : addr_bit;
    code   = absent ? CODE_ABSENT : pack_code(dir, comp_bit, addr_bit);
  end

endmodule

// File: rtl/slot_watchdog.sv
module slot_watchdog #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expired
);

  localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || restart) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = run && (cnt == LAST);

endmodule

// File: rtl/triplet_ctrl.sv
module triplet_ctrl
  import triplet_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pref_dir,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_bit,
  input  logic              expired,
  input  logic              dec_dir,
  input  logic [CODE_W-1:0] dec_code,
  output logic              req_valid,
  output logic              req_write,
  output logic              req_bit,
  output logic              run,
  output logic              complete,
  output logic              addr_q,
  output logic              comp_q,
  output logic              pref_q,
  output logic              done,
  output logic [CODE_W-1:0] result,
  output logic              timeout_err
);

  seq_state_e state;
  slot_kind_e slot;

  logic absent_now;

  always_comb begin
    req_valid  = (state == ST_REQ);
    req_write  = (slot == SL_DIR);
    req_bit    = (slot == SL_DIR) && dec_dir;
    run        = (state != ST_IDLE);
    complete   = (state == ST_WAIT) && rsp_valid;
    absent_now = addr_q && rsp_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      slot        <= SL_ADDR;
      addr_q      <= 1'b0;
      comp_q      <= 1'b0;
      pref_q      <= 1'b0;
      done        <= 1'b0;
      result      <= '0;
      timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_REQ;
            slot   <= SL_ADDR;
            pref_q <= pref_dir;
          end
        end
        ST_REQ: begin
          if (expired) begin
            state       <= ST_IDLE;
            done        <= 1'b1;
            result      <= CODE_ABSENT;
            timeout_err <= 1'b1;
          end else if (req_ready) begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            unique case (slot)
              SL_ADDR: begin
                addr_q <= rsp_bit;
                slot   <= SL_COMP;
                state  <= ST_REQ;
              end
              SL_COMP: begin
                comp_q <= rsp_bit;
                if (absent_now) begin
                  state       <= ST_IDLE;
                  done        <= 1'b1;
                  result      <= CODE_ABSENT;
                  timeout_err <= 1'b0;
                end else begin
                  slot  <= SL_DIR;
                  state <= ST_REQ;
                end
              end
              default: begin
                state       <= ST_IDLE;
                done        <= 1'b1;
                result      <= dec_code;
                timeout_err <= 1'b0;
              end
            endcase
          end else if (expired) begin
            state       <= ST_IDLE;
            done        <= 1'b1;
            result      <= CODE_ABSENT;
            timeout_err <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/triplet_seq.sv
module triplet_seq
  import triplet_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pref_dir,
  output logic              slot_req_valid,
  input  logic              slot_req_ready,
  output logic              slot_req_write,
  output logic              slot_req_bit,
  input  logic              slot_rsp_valid,
  input  logic              slot_rsp_bit,
  output logic              done,
  output logic [CODE_W-1:0] result,
  output logic              timeout_err
);

  logic              slot_run;
  logic              slot_complete;
  logic              slot_expired;
  logic              addr_q;
  logic              comp_q;
  logic              pref_q;
  logic              dec_dir;
  logic [CODE_W-1:0] dec_code;

  triplet_decide u_decide (
    .addr_bit (addr_q),
    .comp_bit (comp_q),
    .pref     (pref_q),
    .dir      (dec_dir),
    .code     (dec_code)
  );

  slot_watchdog #(.LIMIT(TIMEOUT_CYCLES)) u_watchdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (slot_run),
    .restart (slot_complete),
    .expired (slot_expired)
  );

  triplet_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .pref_dir    (pref_dir),
    .req_ready   (slot_req_ready),
    .rsp_valid   (slot_rsp_valid),
    .rsp_bit     (slot_rsp_bit),
    .expired     (slot_expired),
    .dec_dir     (dec_dir),
    .dec_code    (dec_code),
    .req_valid   (slot_req_valid),
    .req_write   (slot_req_write),
    .req_bit     (slot_req_bit),
    .run         (slot_run),
    .complete    (slot_complete),
    .addr_q      (addr_q),
    .comp_q      (comp_q),
    .pref_q      (pref_q),
    .done        (done),
    .result      (result),
    .timeout_err (timeout_err)
  );

endmodule

// File: rtl/triplet_seq_chk.sv
module triplet_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slot_req_valid,
  input logic       slot_req_ready,
  input logic       slot_req_write,
  input logic       slot_req_bit,
  input logic       slot_expired,
  input logic       done,
  input logic [2:0] result,
  input logic       timeout_err
);

  // R2: a pending request holds until taken, unless the step aborts
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req_valid && !slot_req_ready && !slot_expired |=>
      slot_req_valid && $stable(slot_req_write) && $stable(slot_req_bit));

  // R8: expiry while requesting withdraws the request and ends the step
  p_abort_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_expired && slot_req_valid |=> !slot_req_valid && done && timeout_err);

  // R8: an aborted step reports the absent code
  p_abort_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && timeout_err |-> result == 3'b011);

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: outcome holds between completions
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result) && $stable(timeout_err));

  // R1: the step is over when done is reported, so no request is raised
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !slot_req_valid);

  // R4: nobody present never selects direction 1
  p_absent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !timeout_err && result[1:0] == 2'b11 |-> !result[2]);

  // R6: a single answering value decides the direction
  p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !timeout_err && (result[0] ^ result[1]) |-> result[2] == result[0]);

endmodule

bind triplet_seq triplet_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .slot_req_valid (slot_req_valid),
  .slot_req_ready (slot_req_ready),
  .slot_req_write (slot_req_write),
  .slot_req_bit   (slot_req_bit),
  .slot_expired   (slot_expired),
  .done           (done),
  .result         (result),
  .timeout_err    (timeout_err)
);

// File: tb/tb_triplet_seq.sv
module tb_triplet_seq;

  localparam int LIMIT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       pref_dir = 1'b0;
  logic       slot_req_ready = 1'b0;
  logic       slot_rsp_valid = 1'b0;
  logic       slot_rsp_bit = 1'b0;
  logic       slot_req_valid;
  logic       slot_req_write;
  logic       slot_req_bit;
  logic       done;
  logic [2:0] result;
  logic       timeout_err;

  always #10 clk = ~clk;

  triplet_seq #(.TIMEOUT_CYCLES(LIMIT)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .pref_dir       (pref_dir),
    .slot_req_valid (slot_req_valid),
    .slot_req_ready (slot_req_ready),
    .slot_req_write (slot_req_write),
    .slot_req_bit   (slot_req_bit),
    .slot_rsp_valid (slot_rsp_valid),
    .slot_rsp_bit   (slot_rsp_bit),
    .done           (done),
    .result         (result),
    .timeout_err    (timeout_err)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R10";

  task automatic chk1(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s]: actual %b expected %b", what, tag, act, exp);
    end
  endtask

  task automatic chk3(input logic [2:0] act, input logic [2:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s]: actual %b expected %b", what, tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int       m_phase = 0;   // 0 idle, 1 address read, 2 complement read, 3 direction write
  int       m_wait = 0;
  bit       m_acc = 0;
  bit       m_pref = 0, m_id = 0, m_cp = 0, m_dir = 0;
  bit       e_done = 0;
  bit [2:0] e_res = 3'b000;
  bit       e_err = 0;

  task automatic m_end(input bit [2:0] code, input bit err);
    e_done  = 1;
    e_res   = code;
    e_err   = err;
    m_phase = 0;
    m_acc   = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_wait = 0; m_acc = 0;
      e_done = 0; e_res = 3'b000; e_err = 0;
    end else begin
      e_done = 0;
      if (m_phase == 0) begin
        if (start) begin
          m_phase = 1; m_pref = pref_dir; m_acc = 0; m_wait = 0;
        end
      end else if (m_acc && slot_rsp_valid) begin
        m_acc = 0; m_wait = 0;
        if (m_phase == 1) begin
          m_id = slot_rsp_bit; m_phase = 2;
        end else if (m_phase == 2) begin
          m_cp = slot_rsp_bit;
          if (m_id && m_cp) m_end(3'b011, 0);
          else begin
            m_dir   = (m_id != m_cp) ? m_id : m_pref;
            m_phase = 3;
          end
        end else begin
          m_end({m_dir, m_cp, m_id}, 0);
        end
      end else begin
        if (!m_acc && slot_req_ready) m_acc = 1;
        m_wait++;
        if (m_wait >= LIMIT) m_end(3'b011, 1);
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk1(slot_req_valid, (m_phase != 0) && !m_acc, "R2/R3 slot_req_valid");
      if (m_phase != 0 && !m_acc) begin
        chk1(slot_req_write, m_phase == 3, "R2 slot_req_write");
        chk1(slot_req_bit, (m_phase == 3) && m_dir, "R7 slot_req_bit");
      end
      chk1(done, e_done, "R9 done");
      chk3(result, e_res, "R7 result");
      chk1(timeout_err, e_err, "R8 timeout_err");
    end
  end

  // ---------------- slot engine model ----------------
  int  ready_delay = 0, rsp_delay = 0, hang_slot = -1;
  bit  hang_ready = 0, spurious = 0;
  int  rdy_cnt = 0, rsp_cnt = 0, slot_idx = 0;
  bit  pending = 0, pend_write = 0, seen_valid = 0, seen_write = 0;
  bit  bits_q[$];

  always @(negedge clk) begin
    if (!rst_n) begin
      slot_req_ready = 0; slot_rsp_valid = 0; pending = 0; rdy_cnt = 0;
      seen_valid = 0;
    end else begin
      slot_rsp_valid = 0;
      if (slot_req_ready && seen_valid) begin
        pending = 1; rsp_cnt = 0; pend_write = seen_write; slot_req_ready = 0;
      end
      if (pending) begin
        if (!(hang_slot == slot_idx && !hang_ready)) begin
          if (rsp_cnt >= rsp_delay) begin
            slot_rsp_valid = 1;
            slot_rsp_bit   = (pend_write || bits_q.size() == 0) ? 1'b0 : bits_q.pop_front();
            pending = 0;
            slot_idx++;
          end else rsp_cnt++;
        end
      end else if (slot_req_valid) begin
        if (spurious && !slot_req_ready) begin
          slot_rsp_valid = 1; slot_rsp_bit = 1;
        end
        if (!(hang_ready && hang_slot == slot_idx)) begin
          rdy_cnt++;
          if (rdy_cnt > ready_delay) begin
            slot_req_ready = 1; rdy_cnt = 0;
          end
        end
      end else if (spurious) begin
        slot_rsp_valid = 1; slot_rsp_bit = 1;
      end
      seen_valid = slot_req_valid;
      seen_write = slot_req_write;
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_step(input bit a, input bit c, input bit pref, input int rdy_d, input int rsp_d,
                          input int hslot, input bit hrdy, input bit spur, input bit poke,
                          input logic [2:0] exp_code, input logic exp_err, input string t);
    logic [2:0] held;
    bit got = 0;
    @(negedge clk); #1;
    tag = t;
    slot_req_ready = 0; slot_rsp_valid = 0; pending = 0; rdy_cnt = 0; slot_idx = 0;
    seen_valid = 0;
    bits_q.delete(); bits_q.push_back(a); bits_q.push_back(c);
    ready_delay = rdy_d; rsp_delay = rsp_d; hang_slot = hslot; hang_ready = hrdy; spurious = spur;
    start = 1; pref_dir = pref;
    @(negedge clk); #1;
    start = 0;
    pref_dir = ~pref;  // R1: a change after start must not alter the step
    if (poke) begin
      @(negedge clk); #1;
      start = 1;       // R1: start while busy must be ignored
      @(negedge clk); #1;
      start = 0;
    end
    for (int i = 0; i < 8 * LIMIT; i++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
    end
    chk1(got, 1'b1, {t, " done seen"});
    chk3(result, exp_code, {t, " final code"});
    chk1(timeout_err, exp_err, {t, " error flag"});
    held = result;
    @(negedge clk);
    chk1(done, 1'b0, "R9 done falls after one cycle");
    chk3(result, held, "R9 result held");
    #1 spurious = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R10";
    chk1(slot_req_valid, 1'b0, "R10 reset request");
    chk1(done, 1'b0, "R10 reset done");
    chk3(result, 3'b000, "R10 reset result");
    chk1(timeout_err, 1'b0, "R10 reset error");
    #1 rst_n = 1;
    repeat (2) @(negedge clk);

    // R6 single answering value, both polarities
    run_step(1, 0, 0, 0, 0, -1, 0, 0, 0, 3'b101, 1'b0, "R6 addr=1");
    run_step(0, 1, 1, 2, 3, -1, 0, 0, 0, 3'b010, 1'b0, "R6 comp=1");
    // R5 disagreement uses captured preference
    run_step(0, 0, 1, 1, 2, -1, 0, 0, 0, 3'b100, 1'b0, "R5 pref=1");
    run_step(0, 0, 0, 0, 1, -1, 0, 0, 0, 3'b000, 1'b0, "R5 pref=0");
    // R4 nobody present, no write slot (per-cycle model catches a write)
    run_step(1, 1, 1, 3, 0, -1, 0, 0, 0, 3'b011, 1'b0, "R4 absent");
    // R8 response withheld in address read, ready withheld in write slot
    run_step(1, 0, 0, 0, 0, 0, 0, 0, 0, 3'b011, 1'b1, "R8 rsp hang");
    run_step(0, 1, 0, 0, 0, 2, 1, 0, 0, 3'b011, 1'b1, "R8 ready hang");
    run_step(0, 0, 1, 0, 0, 1, 0, 0, 0, 3'b011, 1'b1, "R8 comp hang");
    // R8 boundary: completion in the last allowed cycle vs one later
    run_step(1, 0, 1, 0, LIMIT - 2, -1, 0, 0, 0, 3'b101, 1'b0, "R8 last cycle ok");
    run_step(1, 0, 1, 0, LIMIT - 1, -1, 0, 0, 0, 3'b011, 1'b1, "R8 one cycle late");
    // R1 start while busy, R11 stray responses, R3 ordering via per-cycle model
    run_step(0, 0, 0, 3, 1, -1, 0, 0, 1, 3'b000, 1'b0, "R1 busy start");
    run_step(1, 0, 0, 3, 2, -1, 0, 1, 0, 3'b101, 1'b0, "R11 stray rsp");
    run_step(0, 1, 1, 2, 0, -1, 0, 1, 1, 3'b010, 1'b0, "R3 R11 mixed");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule